// File: doc/BRIEF.md
# Status Flag Generator

This block produces the packed flag word of a small processor. For each operation it receives two operands, a carry-in, an operation code and a byte/word width select. It forms the arithmetic or logic result internally, takes the six status flags from that result, and registers them. The status flags are carry, parity, auxiliary carry, zero, sign and overflow. Next to them the block holds three control flags: direction, interrupt-enable and trap. Each control flag has its own set and clear command, and the commands act whether or not an operation is presented in the same cycle.

All state is in one packed 16-bit word that a flag-reading path can use directly. An operation is taken on the rising clock edge at which `opValid` is high, and the flags it produces appear after that edge. When no valid operation is presented, the status flags keep their values. Instruction decoding, shifts and multiplies belong to other blocks.

Top module: `status_flag_gen`

## Requirements
- R1: While `rstN` is low, `flagWord` reads 16'h0002. All status and control flags are cleared, including interrupt-enable.
- R2: The bit positions in `flagWord` are: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trap 8, interrupt-enable 9, direction 10, overflow 11. Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R3: For arithmetic codes, carry is set on a carry out of, or a borrow into, the most significant bit of the selected width. That bit is 7 when `wordMode` is 0 and 15 when it is 1. In byte mode, operand bits 15:8 have no effect on any flag.
- R4: For arithmetic codes, auxiliary carry is set on a carry out of, or a borrow into, result bit 3.
- R5: Parity is set when result bits 7:0 hold an even number of ones. This holds in word mode too, where bits 15:8 are not counted.
- R6: Zero is set when the result, within the selected width, is all zeros. Sign equals the most significant result bit of that width.
- R7: For arithmetic codes, overflow is set when the true signed result lies outside the two's-complement range of the selected width.
- R8: The logic codes clear carry, overflow and auxiliary carry, and set sign, zero and parity from the result.
- R9: The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 and, 5 or, 6 xor. `carryIn` is used only by codes 1 and 3. Code 7, or `opValid` low, leaves every status flag unchanged.
- R10: Each of direction, interrupt-enable and trap is set by its set command and cleared by its clear command. When both commands are high, clear wins. With neither high, the flag holds its value, whatever the status path does.
- R11: An operation or command sampled at a rising edge shows on `flagWord` after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation code (see R9) |
| wordMode | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opA | input | 16 | First operand (minuend for subtract) |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry or borrow in, used by codes 1 and 3 |
| setDir | input | 1 | Set direction flag |
| clrDir | input | 1 | Clear direction flag |
| setIntEn | input | 1 | Set interrupt-enable flag |
| clrIntEn | input | 1 | Clear interrupt-enable flag |
| setTrap | input | 1 | Set trap flag |
| clrTrap | input | 1 | Clear trap flag |
| flagWord | output | 16 | Packed flag register |

## Verification
The hardest case to reach is a byte operation whose signed overflow, borrow or zero result depends only on the low byte while the upper operand bytes hold values that would change every flag at word width. Directed cases cover the byte and word overflow and borrow boundaries, and the random stimulus keeps arbitrary upper bytes on all byte operations. Control commands are mixed into arithmetic cycles, including cycles where set and clear are both high, so that control-flag priority is exercised while the status path is also updating.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int FLAG_W = 16;
  localparam int CF_POS = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;
  localparam int CTRL_N = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_NONE = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicSel_e;

  typedef struct packed {
    logic loadStatus;
    logic isLogic;
    logic isSub;
    logic useCarry;
    logicSel_e logicSel;
    logic [CTRL_N-1:0] ctrlSet;  // [0] trap, [1] int-enable, [2] direction
    logic [CTRL_N-1:0] ctrlClr;
  } strobe_t;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } status_t;
endpackage

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
  import sfg_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       setDir,
  input  logic       clrDir,
  input  logic       setIntEn,
  input  logic       clrIntEn,
  input  logic       setTrap,
  input  logic       clrTrap,
  output strobe_t    strb
);
  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    strb = '0;
    strb.logicSel = LG_AND;
    unique case (op)
      OP_ADD: begin strb.loadStatus = opValid; end
      OP_ADC: begin strb.loadStatus = opValid; strb.useCarry = 1'b1; end
      OP_SUB: begin strb.loadStatus = opValid; strb.isSub = 1'b1; end
      OP_SBB: begin strb.loadStatus = opValid; strb.isSub = 1'b1; strb.useCarry = 1'b1; end
      OP_AND: begin strb.loadStatus = opValid; strb.isLogic = 1'b1; strb.logicSel = LG_AND; end
      OP_OR:  begin strb.loadStatus = opValid; strb.isLogic = 1'b1; strb.logicSel = LG_OR; end
      OP_XOR: begin strb.loadStatus = opValid; strb.isLogic = 1'b1; strb.logicSel = LG_XOR; end
      OP_NONE: begin strb.loadStatus = 1'b0; end
    endcase
    strb.ctrlSet = {setDir, setIntEn, setTrap};
    strb.ctrlClr = {clrDir, clrIntEn, clrTrap};
  end
endmodule

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              wordMode,
  input  strobe_t           strb,
  output logic [FLAG_W-1:0] flagWord
);
  localparam int EXT_W   = DATA_W + 1;
  localparam int HI_W    = DATA_W - BYTE_W;
  localparam int NIB_BIT = BYTE_W / 2;
  localparam int CTRL_POS [CTRL_N] = '{TF_POS, IF_POS, DF_POS};

  logic [DATA_W-1:0] aEff, bEff, logicRes, res;
  logic [EXT_W-1:0]  arith;
  logic              cinEff, msbA, msbB, msbRes, cyOut, zeroRes, ovf, auxC;
  status_t           statusD, statusQ;
  logic [CTRL_N-1:0] ctrlQ;

  assign aEff   = wordMode ? opA : {{HI_W{1'b0}}, opA[BYTE_W-1:0]};
  assign bEff   = wordMode ? opB : {{HI_W{1'b0}}, opB[BYTE_W-1:0]};
  assign cinEff = strb.useCarry & carryIn;

  always_comb begin
    if (strb.isSub) arith = {1'b0, aEff} - {1'b0, bEff} - EXT_W'(cinEff);
    else            arith = {1'b0, aEff} + {1'b0, bEff} + EXT_W'(cinEff);
  end

  always_comb begin
    unique case (strb.logicSel)
      LG_OR:   logicRes = aEff | bEff;
      LG_XOR:  logicRes = aEff ^ bEff;
      default: logicRes = aEff & bEff;
    endcase
  end

  assign res     = strb.isLogic ? logicRes : arith[DATA_W-1:0];
  assign msbA    = wordMode ? aEff[DATA_W-1] : aEff[BYTE_W-1];
  assign msbB    = wordMode ? bEff[DATA_W-1] : bEff[BYTE_W-1];
  assign msbRes  = wordMode ? res[DATA_W-1]  : res[BYTE_W-1];
  assign cyOut   = wordMode ? arith[DATA_W]  : arith[BYTE_W];
  assign zeroRes = wordMode ? (res == '0) : (res[BYTE_W-1:0] == '0);
  assign auxC    = aEff[NIB_BIT] ^ bEff[NIB_BIT] ^ arith[NIB_BIT];
  assign ovf     = strb.isSub ? ((msbA != msbB) && (msbRes != msbA))
                              : ((msbA == msbB) && (msbRes != msbA));

  always_comb begin
    statusD.cf = strb.isLogic ? 1'b0 : cyOut;
    statusD.af = strb.isLogic ? 1'b0 : auxC;
    statusD.of = strb.isLogic ? 1'b0 : ovf;
    statusD.pf = ~^res[BYTE_W-1:0];
    statusD.zf = zeroRes;
    statusD.sf = msbRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statusQ <= '0;
    else if (strb.loadStatus) statusQ <= statusD;
  end

  for (genvar k = 0; k < CTRL_N; k++) begin : g_ctrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 ctrlQ[k] <= 1'b0;
      else if (strb.ctrlClr[k])  ctrlQ[k] <= 1'b0;
      else if (strb.ctrlSet[k])  ctrlQ[k] <= 1'b1;
    end
  end

  always_comb begin
    flagWord          = '0;
    flagWord[ONE_POS] = 1'b1;
    flagWord[CF_POS]  = statusQ.cf;
    flagWord[PF_POS]  = statusQ.pf;
    flagWord[AF_POS]  = statusQ.af;
    flagWord[ZF_POS]  = statusQ.zf;
    flagWord[SF_POS]  = statusQ.sf;
    flagWord[OF_POS]  = statusQ.of;
    for (int k = 0; k < CTRL_N; k++) flagWord[CTRL_POS[k]] = ctrlQ[k];
  end
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
  import sfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              setDir,
  input  logic              clrDir,
  input  logic              setIntEn,
  input  logic              clrIntEn,
  input  logic              setTrap,
  input  logic              clrTrap,
  output logic [FLAG_W-1:0] flagWord
);
  strobe_t strb;

  sfg_ctrl u_ctrl (
    .opValid(opValid), .opCode(opCode),
    .setDir(setDir), .clrDir(clrDir),
    .setIntEn(setIntEn), .clrIntEn(clrIntEn),
    .setTrap(setTrap), .clrTrap(clrTrap),
    .strb(strb)
  );

  sfg_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .wordMode(wordMode), .strb(strb), .flagWord(flagWord)
  );
endmodule

// File: rtl/status_flag_gen_chk.sv
module status_flag_gen_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic              wordMode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              carryIn,
  input logic              setDir,
  input logic              clrDir,
  input logic              setIntEn,
  input logic              clrIntEn,
  input logic              setTrap,
  input logic              clrTrap,
  input logic [15:0]       flagWord
);
  logic unusedIn;
  assign unusedIn = ^{wordMode, opA, opB, carryIn, setTrap, clrTrap};

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[1] && !flagWord[3] && !flagWord[5] && (flagWord[15:12] == 4'd0)); // R2

  AST_ZERO_NOT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[6] |-> !flagWord[7]); // R6

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 3'd4 && opCode <= 3'd6) |=> (!flagWord[0] && !flagWord[4] && !flagWord[11])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opCode == 3'd7) |=> $stable({flagWord[11], flagWord[7:6], flagWord[4], flagWord[2], flagWord[0]})); // R9

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrDir |=> !flagWord[10]); // R10

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (setDir && !clrDir) |=> flagWord[10]); // R10

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!setIntEn && !clrIntEn) |=> $stable(flagWord[9])); // R10
endmodule

bind status_flag_gen status_flag_gen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_status_flag_gen.sv
`timescale 1ns/1ps
module tb_status_flag_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic        wordMode = 1'b0;
  logic [15:0] opA = 16'd0, opB = 16'd0;
  logic        carryIn = 1'b0;
  logic        setDir = 1'b0, clrDir = 1'b0, setIntEn = 1'b0, clrIntEn = 1'b0, setTrap = 1'b0, clrTrap = 1'b0;
  logic [15:0] flagWord;

  int checks = 0;
  int errors = 0;
  logic [15:0] expWord = 16'h0002;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  status_flag_gen dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refNext(input logic [15:0] cur);
    logic [15:0] w;
    int a, b, c, msb, half, mask, r, sa, sb, sr, res, ones;
    bit sub, cy, af, of;
    w = cur;
    if (opValid && opCode <= 3'd6) begin
      mask = wordMode ? 65535 : 255;
      msb  = wordMode ? 15 : 7;
      half = 1 << msb;
      a = int'(opA) & mask;
      b = int'(opB) & mask;
      c = (opCode == 3'd1 || opCode == 3'd3) ? int'(carryIn) : 0;
      if (opCode <= 3'd3) begin
        sub = (opCode >= 3'd2);
        r  = sub ? a - b - c : a + b + c;
        cy = sub ? (r < 0) : (r > mask);
        af = ((a ^ b ^ r) >> 4) & 1;
        sa = (a >= half) ? a - 2 * half : a;
        sb = (b >= half) ? b - 2 * half : b;
        sr = sub ? sa - sb - c : sa + sb + c;
        of = (sr >= half) || (sr < -half);
        res = r & mask;
      end else begin
        res = (opCode == 3'd4) ? (a & b) : (opCode == 3'd5) ? (a | b) : (a ^ b);
        cy = 0; af = 0; of = 0;
      end
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
      w[0]  = cy;
      w[2]  = (ones % 2) == 0;
      w[4]  = af;
      w[6]  = (res == 0);
      w[7]  = (res >> msb) & 1;
      w[11] = of;
    end
    if (clrDir) w[10] = 1'b0; else if (setDir) w[10] = 1'b1;
    if (clrIntEn) w[9] = 1'b0; else if (setIntEn) w[9] = 1'b1;
    if (clrTrap) w[8] = 1'b0; else if (setTrap) w[8] = 1'b1;
    w[1] = 1'b1;
    return w;
  endfunction

  task automatic compareAll(input bit wasLogic, input bit wasIdle);
    check(wasLogic ? "R8 carry" : "R3 carry", {15'd0, flagWord[0]}, {15'd0, expWord[0]});
    check("R5 parity", {15'd0, flagWord[2]}, {15'd0, expWord[2]});
    check(wasLogic ? "R8 aux" : "R4 aux", {15'd0, flagWord[4]}, {15'd0, expWord[4]});
    check("R6 zero/sign", {14'd0, flagWord[7:6]}, {14'd0, expWord[7:6]});
    check(wasLogic ? "R8 overflow" : "R7 overflow", {15'd0, flagWord[11]}, {15'd0, expWord[11]});
    check("R10 control", {13'd0, flagWord[10:8]}, {13'd0, expWord[10:8]});
    check("R2 fixed bits", {flagWord[15:12], flagWord[5], flagWord[3], flagWord[1], 9'd0},
                           {expWord[15:12], expWord[5], expWord[3], expWord[1], 9'd0});
    if (wasIdle) check("R9 idle word", flagWord, expWord);
  endtask

  task automatic step(input bit v, input logic [2:0] op, input bit wm,
                      input logic [15:0] a, input logic [15:0] b, input bit cin, input logic [5:0] cmd);
    bit lg, idle;
    opValid = v; opCode = op; wordMode = wm; opA = a; opB = b; carryIn = cin;
    {setDir, clrDir, setIntEn, clrIntEn, setTrap, clrTrap} = cmd;
    lg = v && op >= 3'd4 && op <= 3'd6;
    idle = !v || op == 3'd7;
    #1;
    check("R11 no early change", flagWord, expWord);
    @(posedge clk);
    expWord = refNext(expWord);
    @(negedge clk);
    compareAll(lg, idle);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 reset word", flagWord, 16'h0002);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", flagWord, 16'h0002);
    // byte overflow at +127 + 1 with junk upper bytes (R7, R4, R3)
    step(1, 3'd0, 0, 16'hAB7F, 16'h5501, 0, 6'b0);
    // word wrap to zero: carry, zero, aux, parity (R3, R6)
    step(1, 3'd0, 1, 16'hFFFF, 16'h0001, 0, 6'b0);
    // byte borrow 0 - 1 (R3)
    step(1, 3'd2, 0, 16'h1200, 16'h0001, 0, 6'b0);
    // word signed overflow 0x8000 - 1 (R7)
    step(1, 3'd2, 1, 16'h8000, 16'h0001, 0, 6'b0);
    // carry-in used by ADC, ignored by ADD (R9)
    step(1, 3'd1, 0, 16'h00FE, 16'h0001, 1, 6'b0);
    step(1, 3'd0, 0, 16'h00FE, 16'h0001, 1, 6'b0);
    step(1, 3'd3, 1, 16'h0000, 16'h0000, 1, 6'b0);
    step(1, 3'd2, 1, 16'h0000, 16'h0000, 1, 6'b0);
    // logic op after carry set clears carry (R8)
    step(1, 3'd0, 1, 16'hFFFF, 16'hFFFF, 0, 6'b0);
    step(1, 3'd6, 1, 16'hF0F0, 16'h0F0F, 0, 6'b0);
    // word parity from low byte only (R5)
    step(1, 3'd5, 1, 16'h0100, 16'h0003, 0, 6'b0);
    // idle and code 7 keep status (R9)
    step(0, 3'd0, 1, 16'hFFFF, 16'h0001, 0, 6'b0);
    step(1, 3'd7, 1, 16'hFFFF, 16'h0001, 0, 6'b0);
    // control flags: set, then set+clear together (R10)
    step(1, 3'd0, 0, 16'h0001, 16'h0001, 0, 6'b101010);
    step(0, 3'd0, 0, 16'h0, 16'h0, 0, 6'b111111);
    step(0, 3'd0, 0, 16'h0, 16'h0, 0, 6'b001000);
    step(1, 3'd4, 1, 16'h0, 16'h0, 0, 6'b000100);
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] cmd;
      cmd = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'b0;
      step($urandom_range(0, 7) != 0, 3'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), cmd);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule